// File: doc/BRIEF.md
# Key-unlocked indexed configuration port

This block is a configuration register file reached through one index port and one data port on an 8-bit host write bus. The port starts locked. It opens only after a two-byte key is written to the index port, and a close byte on the same port locks it again. While the port is open, the host writes a register number to the index port and then writes or reads the value through the data port.

A small set of global registers sits below index 0x30. One of them selects which logical device is active. Each implemented device has its own bank, holding an activate flag, a 16-bit base address, two IRQ numbers, a DMA channel and five free mode bytes. The banks drive their settings continuously onto flat configuration outputs, for use by the peripherals. Of the nine device numbers, 1 and 2 are not implemented.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked. Every bank is inactive, with base 0x0000, both IRQs 0, DMA 4 and mode bytes 0x00. The device select and the common-I/O select are both 0x00.
- R2: The port opens only when the index port receives 0x51 and then, on its very next index write, 0x23. Any other byte after 0x51 restarts the match. A repeated 0x51 counts as a fresh first key byte. Data-port writes do not affect the match.
- R3: While the port is open, writing 0xBB to the index port locks it again and leaves the index register unchanged. Any other index byte written while open is stored as the current index.
- R4: While the port is locked, data-port writes change no register and no output, and rdata_o reads 0xFF.
- R5: Global index 0x07 holds the device select. A write with a value of 9 or more is ignored. Devices 1 and 2 are not implemented: writes to their bank indices are ignored, and reads of bank indices (0x30 and above) return 0xFF while either is selected.
- R6: In the selected bank, the registers sit at these indices: 0x30 bit 0 is the activate flag, 0x60 is the base high byte, 0x61 the base low byte, 0x70 the primary IRQ, 0x72 the second IRQ and 0x74 the DMA channel. Each one drives that device's slice of the outputs: bits [16d+15:16d] of the base output and bits [8d+7:8d] of the IRQ and DMA outputs.
- R7: A data write to global index 0x02 with bit 0 set returns every bank to its reset values. Device select and common-I/O select are kept, and index 0x02 reads 0x00.
- R8: Global index 0x03 is a read/write byte driven on cio_sel_o. Bit 7 is the enable and bits 1:0 pick the port pair.
- R9: Indices 0xF0 to 0xF4 of each implemented bank are plain read/write mode bytes. Unmapped indices read 0x00, and writes to them are ignored.
- R10: While the port is open, rdata_o shows, one cycle after any write, the register at the current index in the currently selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| sel_data_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Data-port read value |
| cfg_open_o | output | 1 | Configuration mode is open |
| cio_sel_o | output | 8 | Common-I/O port-select byte |
| dev_active_o | output | 9 | Activate flag per device |
| dev_base_o | output | 144 | Base address, 16 bits per device |
| dev_irq_o | output | 72 | Primary IRQ, 8 bits per device |
| dev_irq2_o | output | 72 | Second IRQ, 8 bits per device |
| dev_dma_o | output | 72 | DMA channel, 8 bits per device |

## Verification
The assertions take for granted that wr_i is a single-cycle strobe, with sel_data_i and wdata_i valid in the same cycle. They also assume the host never reads the data port at the same moment it writes. The stimulus applies each write for exactly one cycle, between falling edges. It draws index bytes from a pool weighted toward the key, close and mapped indices. It then mixes in device numbers above 8 and rare soft-reset writes, so that the locked, unused-device and out-of-range paths are all reached.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h51;
  localparam logic [7:0] KEY_SECOND = 8'h23;
  localparam logic [7:0] CLOSE_BYTE = 8'hBB;
  localparam logic [7:0] IX_SRST    = 8'h02;
  localparam logic [7:0] IX_CIO     = 8'h03;
  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_BANK0   = 8'h30;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_BASE_LO = 8'h61;
  localparam logic [7:0] IX_IRQ     = 8'h70;
  localparam logic [7:0] IX_IRQ2    = 8'h72;
  localparam logic [7:0] IX_DMA     = 8'h74;
  localparam logic [7:0] IX_MODE0   = 8'hF0;
  localparam int         NMODE      = 5;
  localparam logic [7:0] DMA_NONE   = 8'h04;

  typedef enum logic [1:0] {ST_LOCKED, ST_KEY1, ST_OPEN} key_st_e;

  typedef struct packed {
    logic        act;
    logic [15:0] base;
    logic [7:0]  irq;
    logic [7:0]  irq2;
    logic [7:0]  dma;
  } bank_cfg_t;

  localparam bank_cfg_t BANK_RST = '{act: 1'b0, base: 16'h0, irq: 8'h0,
                                     irq2: 8'h0, dma: DMA_NONE};
endpackage

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      unique case (st_q)
        ST_LOCKED: st_d = (wdata_i == KEY_FIRST) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   st_d = (wdata_i == KEY_SECOND) ? ST_OPEN :
                          (wdata_i == KEY_FIRST)  ? ST_KEY1 : ST_LOCKED;
        ST_OPEN:   st_d = (wdata_i == CLOSE_BYTE) ? ST_LOCKED : ST_OPEN;
        default:   st_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_LOCKED;
    else         st_q <= st_d;

  assign open_o = (st_q == ST_OPEN);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output bank_cfg_t  cfg_o,
  output logic [7:0] rdata_o
);
  bank_cfg_t  cfg_q;
  logic [7:0] mode_q [NMODE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= BANK_RST;
    end else if (clr_i) begin
      cfg_q <= BANK_RST;
    end else if (we_i) begin
      unique case (idx_i)
        IX_ACT:     cfg_q.act       <= wdata_i[0];
        IX_BASE_HI: cfg_q.base[15:8] <= wdata_i;
        IX_BASE_LO: cfg_q.base[7:0]  <= wdata_i;
        IX_IRQ:     cfg_q.irq       <= wdata_i;
        IX_IRQ2:    cfg_q.irq2      <= wdata_i;
        IX_DMA:     cfg_q.dma       <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                mode_q[m] <= 8'h00;
      else if (clr_i)                             mode_q[m] <= 8'h00;
      else if (we_i && idx_i == IX_MODE0 + 8'(m)) mode_q[m] <= wdata_i;
  end

  always_comb begin
    rdata_o = 8'h00;
    unique case (idx_i)
      IX_ACT:     rdata_o = {7'b0, cfg_q.act};
      IX_BASE_HI: rdata_o = cfg_q.base[15:8];
      IX_BASE_LO: rdata_o = cfg_q.base[7:0];
      IX_IRQ:     rdata_o = cfg_q.irq;
      IX_IRQ2:    rdata_o = cfg_q.irq2;
      IX_DMA:     rdata_o = cfg_q.dma;
      default: begin
        for (int m = 0; m < NMODE; m++)
          if (idx_i == IX_MODE0 + 8'(m)) rdata_o = mode_q[m];
      end
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int             NDEV   = 9,
  parameter logic [NDEV-1:0] UNUSED = 9'b0_0000_0110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_data_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              cfg_open_o,
  output logic [7:0]        cio_sel_o,
  output logic [NDEV-1:0]   dev_active_o,
  output logic [NDEV*16-1:0] dev_base_o,
  output logic [NDEV*8-1:0] dev_irq_o,
  output logic [NDEV*8-1:0] dev_irq2_o,
  output logic [NDEV*8-1:0] dev_dma_o
);
  localparam int LDN_W = $clog2(NDEV);

  logic             open;
  logic             idx_wr, data_wr, soft_clr;
  logic [7:0]       idx_q, cio_q;
  logic [LDN_W-1:0] ldn_q;
  bank_cfg_t        cfg_w [NDEV];
  logic [7:0]       bank_rd [NDEV];
  logic [7:0]       sel_rd;

  assign idx_wr   = wr_i && !sel_data_i;
  assign data_wr  = wr_i && sel_data_i && open;
  assign soft_clr = data_wr && idx_q == IX_SRST && wdata_i[0];

  cfg_key_unlock u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_wr_i(idx_wr),
    .wdata_i (wdata_i),
    .open_o  (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      cio_q <= 8'h00;
      ldn_q <= '0;
    end else begin
      if (idx_wr && open && wdata_i != CLOSE_BYTE) idx_q <= wdata_i;
      if (data_wr && idx_q == IX_CIO) cio_q <= wdata_i;
      if (data_wr && idx_q == IX_LDN && wdata_i < 8'(NDEV)) ldn_q <= LDN_W'(wdata_i);
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    if (UNUSED[d]) begin : g_none
      assign cfg_w[d]   = BANK_RST;
      assign bank_rd[d] = 8'hFF;
    end else begin : g_bank
      cfg_dev_bank u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (soft_clr),
        .we_i   (data_wr && idx_q >= IX_BANK0 && ldn_q == LDN_W'(d)),
        .idx_i  (idx_q),
        .wdata_i(wdata_i),
        .cfg_o  (cfg_w[d]),
        .rdata_o(bank_rd[d])
      );
    end
    assign dev_active_o[d]           = cfg_w[d].act;
    assign dev_base_o[16*d +: 16]    = cfg_w[d].base;
    assign dev_irq_o[8*d +: 8]       = cfg_w[d].irq;
    assign dev_irq2_o[8*d +: 8]      = cfg_w[d].irq2;
    assign dev_dma_o[8*d +: 8]       = cfg_w[d].dma;
  end

  always_comb begin
    sel_rd = 8'hFF;
    for (int d = 0; d < NDEV; d++)
      if (ldn_q == LDN_W'(d)) sel_rd = bank_rd[d];
  end

  always_comb begin
    if (!open)                 rdata_o = 8'hFF;
    else if (idx_q >= IX_BANK0) rdata_o = sel_rd;
    else if (idx_q == IX_LDN)  rdata_o = 8'(ldn_q);
    else if (idx_q == IX_CIO)  rdata_o = cio_q;
    else                       rdata_o = 8'h00;
  end

  assign cfg_open_o = open;
  assign cio_sel_o  = cio_q;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int NDEV = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              sel_data_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              cfg_open_o,
  input logic [7:0]        cio_sel_o,
  input logic [NDEV-1:0]   dev_active_o,
  input logic [NDEV*16-1:0] dev_base_o,
  input logic [NDEV*8-1:0] dev_dma_o,
  input logic [7:0]        idx_q
);
  AST_LOCKED_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o |-> rdata_o == 8'hFF); // R4

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_open_o) |-> $past(wr_i && !sel_data_i && wdata_i == 8'h23)); // R2

  AST_CLOSE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_open_o && wr_i && !sel_data_i && wdata_i == 8'hBB |=> !cfg_open_o); // R3

  AST_CLOSE_KEEPS_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !sel_data_i && wdata_i == 8'hBB |=> $stable(idx_q)); // R3

  AST_LOCKED_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o && wr_i && sel_data_i |=>
      $stable(dev_active_o) && $stable(dev_base_o) && $stable(dev_dma_o) &&
      $stable(cio_sel_o)); // R4

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_open_o && wr_i && sel_data_i && idx_q == 8'h02 && wdata_i[0] |=>
      dev_active_o == '0 && dev_base_o == '0); // R7
endmodule

bind keyed_cfg_port cfg_port_chk #(.NDEV(NDEV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .sel_data_i  (sel_data_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .cfg_open_o  (cfg_open_o),
  .cio_sel_o   (cio_sel_o),
  .dev_active_o(dev_active_o),
  .dev_base_o  (dev_base_o),
  .dev_dma_o   (dev_dma_o),
  .idx_q       (idx_q)
);

// File: tb/keyed_cfg_port_tb.sv
`timescale 1ns/1ps
module keyed_cfg_port_tb;
  localparam int NDEV = 9;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, sel_data_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o, cio_sel_o;
  logic cfg_open_o;
  logic [NDEV-1:0] dev_active_o;
  logic [NDEV*16-1:0] dev_base_o;
  logic [NDEV*8-1:0] dev_irq_o, dev_irq2_o, dev_dma_o;

  always #2.5 clk_i = ~clk_i;

  keyed_cfg_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_data_i(sel_data_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cfg_open_o(cfg_open_o),
    .cio_sel_o(cio_sel_o), .dev_active_o(dev_active_o), .dev_base_o(dev_base_o),
    .dev_irq_o(dev_irq_o), .dev_irq2_o(dev_irq2_o), .dev_dma_o(dev_dma_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  int         m_st;
  logic [7:0] m_idx, m_cio, m_ldn;
  logic       m_act  [NDEV];
  logic [15:0] m_base [NDEV];
  logic [7:0] m_irq [NDEV], m_irq2 [NDEV], m_dma [NDEV];
  logic [7:0] m_mode [NDEV][5];

  function automatic bit unused_dev(logic [7:0] d);
    return d == 8'd1 || d == 8'd2;
  endfunction

  task automatic model_banks_rst();
    for (int d = 0; d < NDEV; d++) begin
      m_act[d] = 0; m_base[d] = 0; m_irq[d] = 0; m_irq2[d] = 0; m_dma[d] = 8'h04;
      for (int k = 0; k < 5; k++) m_mode[d][k] = 0;
    end
  endtask

  task automatic model_rst();
    m_st = 0; m_idx = 0; m_cio = 0; m_ldn = 0;
    model_banks_rst();
  endtask

  task automatic model_wr(bit sel, logic [7:0] d);
    int l;
    if (!sel) begin
      case (m_st)
        0: m_st = (d == 8'h51) ? 1 : 0;
        1: m_st = (d == 8'h23) ? 2 : (d == 8'h51) ? 1 : 0;
        default: if (d == 8'hBB) m_st = 0; else m_idx = d;
      endcase
    end else if (m_st == 2) begin
      l = int'(m_ldn);
      if (m_idx == 8'h07 && d < 8'd9) m_ldn = d;
      else if (m_idx == 8'h03) m_cio = d;
      else if (m_idx == 8'h02 && d[0]) model_banks_rst();
      else if (m_idx >= 8'h30 && !unused_dev(m_ldn)) begin
        case (m_idx)
          8'h30: m_act[l] = d[0];
          8'h60: m_base[l][15:8] = d;
          8'h61: m_base[l][7:0] = d;
          8'h70: m_irq[l] = d;
          8'h72: m_irq2[l] = d;
          8'h74: m_dma[l] = d;
          8'hF0, 8'hF1, 8'hF2, 8'hF3, 8'hF4: m_mode[l][m_idx - 8'hF0] = d;
          default: ;
        endcase
      end
    end
  endtask

  function automatic logic [7:0] model_rd();
    int l = int'(m_ldn);
    if (m_st != 2) return 8'hFF;
    if (m_idx >= 8'h30) begin
      if (unused_dev(m_ldn)) return 8'hFF;
      case (m_idx)
        8'h30: return {7'b0, m_act[l]};
        8'h60: return m_base[l][15:8];
        8'h61: return m_base[l][7:0];
        8'h70: return m_irq[l];
        8'h72: return m_irq2[l];
        8'h74: return m_dma[l];
        8'hF0, 8'hF1, 8'hF2, 8'hF3, 8'hF4: return m_mode[l][m_idx - 8'hF0];
        default: return 8'h00;
      endcase
    end
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx == 8'h03) return m_cio;
    return 8'h00;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    check(req, "open", 32'(cfg_open_o), 32'(m_st == 2));
    check(req, "rdata", 32'(rdata_o), 32'(model_rd()));
    check(req, "cio", 32'(cio_sel_o), 32'(m_cio));
    for (int d = 0; d < NDEV; d++) begin
      check(req, "act", 32'(dev_active_o[d]), 32'(m_act[d]));
      check(req, "base", 32'(dev_base_o[16*d +: 16]), 32'(m_base[d]));
      check(req, "irq", 32'(dev_irq_o[8*d +: 8]), 32'(m_irq[d]));
      check(req, "irq2", 32'(dev_irq2_o[8*d +: 8]), 32'(m_irq2[d]));
      check(req, "dma", 32'(dev_dma_o[8*d +: 8]), 32'(m_dma[d]));
    end
  endtask

  // one-cycle write; outputs sampled at the next falling edge
  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; sel_data_i = sel; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    model_wr(sel, d);
  endtask

  task automatic open_port();
    wr(0, 8'h51); wr(0, 8'h23);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    logic [7:0] pool [16] = '{8'h51, 8'h23, 8'hBB, 8'h07, 8'h02, 8'h03, 8'h30, 8'h60,
                              8'h61, 8'h70, 8'h72, 8'h74, 8'hF0, 8'hF2, 8'hF4, 8'h45};
    void'($urandom(seed));
    model_rst();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_outputs("R1");

    // R4: locked data write ignored
    wr(1, 8'h55);
    check("R4", "locked rdata", 32'(rdata_o), 32'hFF);
    check_outputs("R4");

    // R2: interrupted key stays locked; repeated first byte still opens
    wr(0, 8'h51); wr(0, 8'h00); wr(0, 8'h23);
    check("R2", "interrupted key", 32'(cfg_open_o), 0);
    wr(0, 8'h51); wr(1, 8'h00); wr(0, 8'h51); wr(0, 8'h23);
    check("R2", "repeat 51 opens", 32'(cfg_open_o), 1);

    // R6 / R10: device 0 fields
    wr(0, 8'h60); wr(1, 8'h03);
    wr(0, 8'h61); wr(1, 8'hF8);
    wr(0, 8'h74); wr(1, 8'h02);
    wr(0, 8'h30); wr(1, 8'h01);
    check("R6", "dev0 base", 32'(dev_base_o[15:0]), 32'h03F8);
    check("R6", "dev0 dma", 32'(dev_dma_o[7:0]), 32'h02);
    check("R10", "act readback", 32'(rdata_o), 32'h01);

    // R9: mode byte and unmapped index
    wr(0, 8'hF3); wr(1, 8'hA5);
    check("R9", "mode F3", 32'(rdata_o), 32'hA5);
    wr(0, 8'h45); wr(1, 8'h77);
    check("R9", "unmapped", 32'(rdata_o), 32'h00);

    // R5: out-of-range select ignored; unused bank reads FF
    wr(0, 8'h07); wr(1, 8'h09);
    check("R5", "ldn 9 ignored", 32'(rdata_o), 32'h00);
    wr(1, 8'h01);
    wr(0, 8'h70); wr(1, 8'h0B);
    check("R5", "unused bank read", 32'(rdata_o), 32'hFF);
    check_outputs("R5");

    // R8: common-I/O select
    wr(0, 8'h03); wr(1, 8'h83);
    check("R8", "cio_sel", 32'(cio_sel_o), 32'h83);

    // R7: soft reset
    wr(0, 8'h02); wr(1, 8'h01);
    check("R7", "dev0 active", 32'(dev_active_o[0]), 0);
    check("R7", "dev0 dma", 32'(dev_dma_o[7:0]), 32'h04);
    check("R7", "cio kept", 32'(cio_sel_o), 32'h83);
    check_outputs("R7");

    // R3: close keeps index
    wr(0, 8'hBB);
    check("R3", "closed", 32'(cfg_open_o), 0);
    open_port();
    check("R3", "index kept", 32'(rdata_o), 32'h00);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      if ($urandom % 3 == 0) begin
        d = pool[$urandom % 16];
        if ($urandom % 8 == 0) d = 8'($urandom);
        if (m_st != 2 && $urandom % 2 == 0) d = (m_st == 0) ? 8'h51 : 8'h23;
        if (m_st == 2 && d == 8'hBB && $urandom % 2 == 0) d = 8'h60;
        wr(0, d);
      end else begin
        d = 8'($urandom);
        if (m_idx == 8'h07) d = 8'($urandom % 12);
        if (m_idx == 8'h02 && $urandom % 6 != 0) d[0] = 1'b0;
        wr(1, d);
      end
      check("R10", "rand rdata", 32'(rdata_o), 32'(model_rd()));
      if (i % 50 == 0) check_outputs("R6");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule